// File: doc/BRIEF.md
# Shared Gray Counter Capture Bank for a Ramp Converter

This block is the digital half of a many-channel ramp-compare (Wilkinson) converter. A single counter, coded in Gray, runs from zero to full scale while a common analog ramp rises. Every channel owns one capture register. When a channel's comparator output goes high, the register stores the counter code present at that moment. The counter is Gray-coded, so only one bit moves per step. A capture that coincides with a step therefore cannot pick up a mix of the old and new codes.

A one-cycle `start` pulse launches a conversion, which lasts one cycle per code. A channel whose comparator never rises before the count ends is given the full-scale value and flagged as overflowed. The stored codes are decoded to binary at the outputs. A `done` pulse marks the cycle in which every result is final. Each comparator input passes through a synchronizer before the rising-edge detector, so a captured value lags the comparator edge by a fixed number of counts.

Top module: `wk_adc_latch`

## Requirements
- R1: After reset, `busy` and `done` are low, and every result and every overflow flag is zero.
- R2: A `start` pulse while idle raises `busy` on the next cycle. A `start` pulse while `busy` is high is ignored and does not change the running conversion.
- R3: `busy` stays high for exactly 2^NBITS cycles, one per counter code from 0 to 2^NBITS-1. `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R4: The shared counter advances in Gray code: between consecutive busy cycles exactly one bit of the code changes.
- R5: The comparator input passes through SYNC_STAGES flops (default 2). If a comparator rises in the cycle where the counter holds code c, the channel's result is c+SYNC_STAGES.
- R6: Only the first synchronized rising edge after `start` is captured. Later falls and rises on the same channel leave the result unchanged.
- R7: A channel with no captured edge by the last code gets result 2^NBITS-1 and its overflow bit set. This includes an edge that arrives too late for the synchronizer to deliver it in time.
- R8: An edge delivered in the cycle of the last code is a normal capture: result 2^NBITS-1 with overflow clear.
- R9: A comparator that is already high when `start` arrives produces no rising edge, and the channel reports overflow.
- R10: Launching a conversion clears every result and overflow flag, so both read zero in the first busy cycle. Results are presented as plain binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle conversion launch |
| cmp_in | input | NCH | Raw comparator outputs, one per channel |
| result | output | NCH*NBITS | Binary results, channel k at bits [k*NBITS +: NBITS] |
| ovf | output | NCH | Per-channel overflow flag |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The checker watches the control behaviour on every cycle: a launch from idle, the single-cycle `done` that follows the fall of `busy`, the one-bit step of the Gray code, the full-scale value of any overflowed channel, and the cleared flags at the start of a conversion. Only the bench scenarios can show that a captured value equals the comparator's edge time plus the synchronizer latency. The same holds for ignoring later toggles, for the boundary between a capture at the last code and an overflow, for a comparator that is high before launch, and for a restart request during a conversion having no effect.

// File: rtl/wk_pkg.sv
package wk_pkg;
   localparam int unsigned WK_MIN_SYNC = 2;
   localparam int unsigned WK_MAX_BITS = 24;

   function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction
endpackage

// File: rtl/wk_gray_counter.sv
module wk_gray_counter #(
   parameter int unsigned NBITS = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             launch,
   output logic             busy,
   output logic             last,
   output logic             done,
   output logic [NBITS-1:0] gray_q
);
   localparam logic [NBITS-1:0] TOP = {NBITS{1'b1}};

   logic [NBITS-1:0] bin_q;
   logic [NBITS-1:0] bin_nxt;
   logic             busy_q;
   logic             done_q;

   assign bin_nxt = bin_q + 1'b1;
   assign launch  = start && !busy_q;
   assign last    = busy_q && (bin_q == TOP);
   assign busy    = busy_q;
   assign done    = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         gray_q <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            if (bin_q == TOP) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               bin_q  <= '0;
               gray_q <= '0;
            end else begin
               bin_q  <= bin_nxt;
               gray_q <= NBITS'(wk_pkg::bin_to_gray(32'(bin_nxt)));
            end
         end else if (start) begin
            busy_q <= 1'b1;
            bin_q  <= '0;
            gray_q <= '0;
         end
      end
   end
endmodule

// File: rtl/wk_chan_latch.sv
module wk_chan_latch #(
   parameter int unsigned NBITS       = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_raw,
   input  logic             launch,
   input  logic             busy,
   input  logic             last,
   input  logic [NBITS-1:0] gray,
   output logic [NBITS-1:0] code_q,
   output logic             ovf_q
);
   localparam logic [NBITS-1:0] FULL_GRAY = {1'b1, {(NBITS-1){1'b0}}};

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_d;
   logic                   held_q;
   logic                   rise;

   assign rise = sync_q[SYNC_STAGES-1] && !sync_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         sync_d <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], cmp_raw};
         sync_d <= sync_q[SYNC_STAGES-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         ovf_q  <= 1'b0;
         held_q <= 1'b0;
      end else if (launch) begin
         code_q <= '0;
         ovf_q  <= 1'b0;
         held_q <= 1'b0;
      end else if (busy && !held_q) begin
         if (rise) begin
            code_q <= gray;
            held_q <= 1'b1;
         end else if (last) begin
            code_q <= FULL_GRAY;
            ovf_q  <= 1'b1;
            held_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/wk_gray_decode.sv
module wk_gray_decode #(
   parameter int unsigned NBITS = 12
) (
   input  logic [NBITS-1:0] gray,
   output logic [NBITS-1:0] bin
);
   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      assign bin[i] = ^gray[NBITS-1:i];
   end
endmodule

// File: rtl/wk_adc_latch.sv
module wk_adc_latch #(
   parameter int unsigned NCH         = 72,
   parameter int unsigned NBITS       = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [NCH-1:0]       cmp_in,
   output logic [NCH*NBITS-1:0] result,
   output logic [NCH-1:0]       ovf,
   output logic                 busy,
   output logic                 done
);
   if (NBITS < 2 || NBITS > wk_pkg::WK_MAX_BITS) begin : g_bad_bits
      $error("wk_adc_latch: NBITS out of range");
   end
   if (SYNC_STAGES < wk_pkg::WK_MIN_SYNC) begin : g_bad_sync
      $error("wk_adc_latch: SYNC_STAGES below minimum");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("wk_adc_latch: NCH must be positive");
   end

   logic             launch_w;
   logic             last_w;
   logic [NBITS-1:0] gray_w;

   wk_gray_counter #(.NBITS(NBITS)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .launch (launch_w),
      .busy   (busy),
      .last   (last_w),
      .done   (done),
      .gray_q (gray_w)
   );

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic [NBITS-1:0] code;
      wk_chan_latch #(.NBITS(NBITS), .SYNC_STAGES(SYNC_STAGES)) u_lat (
         .clk     (clk),
         .rst_n   (rst_n),
         .cmp_raw (cmp_in[ch]),
         .launch  (launch_w),
         .busy    (busy),
         .last    (last_w),
         .gray    (gray_w),
         .code_q  (code),
         .ovf_q   (ovf[ch])
      );
      wk_gray_decode #(.NBITS(NBITS)) u_dec (
         .gray (code),
         .bin  (result[ch*NBITS +: NBITS])
      );
   end
endmodule

// File: rtl/wk_adc_chk.sv
module wk_adc_chk #(
   parameter int unsigned NCH   = 72,
   parameter int unsigned NBITS = 12
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic                 busy,
   input logic                 done,
   input logic [NBITS-1:0]     gray_q,
   input logic [NCH*NBITS-1:0] result,
   input logic [NCH-1:0]       ovf
);
   localparam logic [NBITS-1:0] MAXV = {NBITS{1'b1}};

   // R2
   launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R3
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R3
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R4
   gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($countones(gray_q ^ $past(gray_q)) == 1));

   // R10
   launch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (ovf == '0));

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      // R7
      ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ovf[i] |-> (result[i*NBITS +: NBITS] == MAXV));
   end
endmodule

bind wk_adc_latch wk_adc_chk #(.NCH(NCH), .NBITS(NBITS)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .gray_q (gray_w),
   .result (result),
   .ovf    (ovf)
);

// File: tb/tb_wk_adc_latch.sv
module tb_wk_adc_latch;
   localparam int CLK_PERIOD = 10;
   localparam int NCH  = 8;
   localparam int NB   = 12;
   localparam int LAT  = 2;
   localparam int MAXV = (1 << NB) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [NCH-1:0]    cmp_in = '0;
   logic [NCH*NB-1:0] result;
   logic [NCH-1:0]    ovf;
   logic              busy, done;

   wk_adc_latch #(.NCH(NCH), .NBITS(NB), .SYNC_STAGES(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
      .result(result), .ovf(ovf), .busy(busy), .done(done));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, fails = 0, cycles = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string msg, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
      end
   endtask

   // behavioural reference of the conversion timeline
   bit m_busy = 0, m_done = 0;
   int m_cnt = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy <= 0; m_done <= 0; m_cnt <= 0;
      end else begin
         m_done <= 0;
         if (m_busy) begin
            if (m_cnt == MAXV) begin m_busy <= 0; m_done <= 1; end
            else m_cnt <= m_cnt + 1;
         end else if (start) begin
            m_busy <= 1; m_cnt <= 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(busy == m_busy, "R2 busy", busy, m_busy);
         chk(done == m_done, "R3 done", done, m_done);
      end
   end

   int f1[NCH], dr[NCH], f2[NCH];
   logic [NCH-1:0] pre;
   int restart_at;

   task automatic run_conv();
      bit first;
      cmp_in = pre;
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      first = 1;
      forever begin
         if (first) begin
            chk(ovf == '0, "R10 ovf cleared at launch", int'(ovf), 0);
            chk(result == '0, "R10 results cleared at launch", int'(result[NB-1:0]), 0);
            first = 0;
         end
         if (m_done) break;
         start = 1'b0;
         if (m_busy) begin
            for (int c = 0; c < NCH; c++) begin
               if (m_cnt == f1[c]) cmp_in[c] = 1'b1;
               if (m_cnt == dr[c]) cmp_in[c] = 1'b0;
               if (m_cnt == f2[c]) cmp_in[c] = 1'b1;
            end
            if (m_cnt == restart_at) start = 1'b1;
         end
         @(negedge clk);
      end
      // done cycle: results final
      for (int c = 0; c < NCH; c++) begin
         int exp_v; bit exp_o; string tag;
         if (pre[c] || f1[c] < 0 || f1[c] + LAT > MAXV) begin
            exp_v = MAXV; exp_o = 1;
            tag = pre[c] ? "R9" : "R7";
         end else begin
            exp_v = f1[c] + LAT; exp_o = 0;
            tag = (exp_v == MAXV) ? "R8" : (dr[c] >= 0 ? "R6" : "R5 R4 R10");
         end
         chk(int'(result[c*NB +: NB]) == exp_v, $sformatf("%s result ch%0d", tag, c),
             int'(result[c*NB +: NB]), exp_v);
         chk(ovf[c] == exp_o, $sformatf("%s ovf ch%0d", tag, c), ovf[c], exp_o);
      end
      cmp_in = '0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(busy == 0, "R1 busy after reset", busy, 0);
      chk(done == 0, "R1 done after reset", done, 0);
      chk(ovf == '0, "R1 ovf after reset", int'(ovf), 0);
      chk(result == '0, "R1 result after reset", int'(result[NB-1:0]), 0);

      // first conversion: spread edges, toggles, late edges, restart attempt (R2)
      f1 = '{0, 100, 2047, 4093, 4094, -1, 500, 1234};
      dr = '{-1, -1, -1, -1, -1, -1, 510, -1};
      f2 = '{-1, -1, -1, -1, -1, -1, 600, -1};
      pre = '0;
      restart_at = 1000;
      run_conv();

      // second conversion: flags cleared, comparator high before launch
      f1 = '{7, -1, 3000, -1, 1, 4000, 4092, 55};
      dr = '{20, -1, -1, -1, -1, -1, -1, 60};
      f2 = '{30, -1, -1, -1, -1, -1, -1, 70};
      pre = 8'b0000_1000;
      restart_at = -1;
      run_conv();

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000 && !finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule